// File: doc/BRIEF.md
# Serial Register Port with Sample Formatting

This block is a serial slave that gives a host read and write access to a small bank of 8-bit registers. It serves three trim registers, one control register, and six read-only bytes that show three 12-bit signed sample inputs. Each access is framed by an active-low chip select and lasts sixteen serial clock pulses. The first bit is the direction: 1 means read and 0 means write. The next seven bits give the register address and the last eight bits carry the data byte. Both address and data are sent most significant bit first.

The serial inputs are brought into the system clock domain through synchronizers. The block detects serial clock edges there. It captures input bits on rising serial clock edges and moves output bits on falling edges. One control bit selects the output path. Read data goes either to a dedicated output pin (4-wire) or back onto the shared data pin with an output enable (3-wire). A second control bit sets how each sample is laid out in its 16-bit byte pair: right-justified with sign extension, or left-justified with zero fill.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, the trim registers and the control register read 0, and `sdio_oe` and `miso_o` are low.
- R2: A frame whose first bit is 0 writes its eight data bits, MSB first, on the sixteenth rising serial clock edge. Trim registers sit at 16h, 17h and 18h. The control register sits at 20h and keeps only bit 0 (3-wire) and bit 1 (left-justify); its bits 7:2 read 0.
- R3: A frame whose first bit is 1 returns the addressed byte, MSB first. Each bit changes on a falling serial clock edge, starting with the falling edge after the eighth rising edge, and is stable for the following rising edge.
- R4: With control bit 0 cleared, read data appears on `miso_o` and `sdio_oe` stays low.
- R5: With control bit 0 set, read data appears on `sdio_o`. `sdio_oe` is high only during the data phase of a read, and `miso_o` stays low.
- R6: With control bit 1 cleared, each sample's low byte (X 28h, Y 2Ah, Z 2Ch) holds sample bits 7:0. The high byte (29h, 2Bh, 2Dh) holds sample bit 11 repeated four times above sample bits 11:8.
- R7: With control bit 1 set, the high byte holds sample bits 11:4 and the low byte holds sample bits 3:0 followed by four zeros.
- R8: Raising chip select before the sixteenth rising edge aborts the frame and leaves every register unchanged.
- R9: Writes to the sample bytes or to unused addresses change nothing, and reads from unused addresses return 0.
- R10: While chip select is inactive, `miso_o` and `sdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, idle high |
| sdio_i | input | 1 | Serial data in (shared data pin, input side) |
| sdio_o | output | 1 | Shared data pin, output side (3-wire reads) |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| miso_o | output | 1 | Dedicated read data output (4-wire mode) |
| smp_x | input | SMP_W | X sample, two's complement |
| smp_y | input | SMP_W | Y sample, two's complement |
| smp_z | input | SMP_W | Z sample, two's complement |

## Verification
The bench builds the block with its defaults: two synchronizer stages and 12-bit samples. Each serial clock phase lasts eight system clocks, which leaves room for the synchronizer and edge-detect latency before the host samples. The 12-bit width puts four padding bits in every high byte. Negative and positive samples therefore make the sign-extension and zero-fill paths visibly differ. Frames are cut short at ten and fifteen clocks to reach the abort path.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 2;
  localparam int FRAME  = 1 + ADDR_W + DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // addresses of the trim registers and the sample bytes are fixed by the host software map
  localparam addr_t A_TRIM_X = 7'h16;
  localparam addr_t A_TRIM_Y = 7'h17;
  localparam addr_t A_TRIM_Z = 7'h18;
  localparam addr_t A_CTRL   = 7'h20;
  localparam addr_t A_X_LO   = 7'h28;
  localparam addr_t A_X_HI   = 7'h29;
  localparam addr_t A_Y_LO   = 7'h2A;
  localparam addr_t A_Y_HI   = 7'h2B;
  localparam addr_t A_Z_LO   = 7'h2C;
  localparam addr_t A_Z_HI   = 7'h2D;

  localparam int CTRL_WIRE3 = 0;
  localparam int CTRL_LJUST = 1;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic rst_sn,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  logic [1:0]        rst_q;
  logic [STAGES-1:0] cs_q, ck_q, di_q, cs_nx, ck_nx, di_nx;
  logic              ck_prev_q;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  always_comb begin
    cs_nx = {cs_q[STAGES-2:0], cs_n};
    ck_nx = {ck_q[STAGES-2:0], sclk};
    di_nx = {di_q[STAGES-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cs_q      <= '1;
      ck_q      <= '1;
      di_q      <= '0;
      ck_prev_q <= 1'b1;
    end else begin
      cs_q      <= cs_nx;
      ck_q      <= ck_nx;
      di_q      <= di_nx;
      ck_prev_q <= ck_q[STAGES-1];
    end
  end

  assign cs_act    = ~cs_q[STAGES-1];
  assign sclk_rise =  ck_q[STAGES-1] & ~ck_prev_q;
  assign sclk_fall = ~ck_q[STAGES-1] &  ck_prev_q;
  assign sdi_s     =  di_q[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sdi,
  input  byte_t            rd_data,
  output addr_t            addr,
  output logic             wr_en,
  output byte_t            wr_data,
  output logic             rd_flag,
  output logic             out_en,
  output logic             out_bit,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam int SH_W = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;
  localparam logic [CNT_W-1:0] C_ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_DATA_FST  = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] C_LAST      = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] C_END       = CNT_W'(FRAME);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [SH_W-1:0]  sh_q, sh_nx;
  logic             rw_q, rw_nx, oe_q, oe_nx, ob_q, ob_nx;
  addr_t            addr_q, addr_nx;
  byte_t            tx_q, tx_nx;

  assign wr_data = {sh_q[DATA_W-2:0], sdi};

  always_comb begin
    cnt_nx  = cnt_q;
    sh_nx   = sh_q;
    rw_nx   = rw_q;
    addr_nx = addr_q;
    tx_nx   = tx_q;
    oe_nx   = oe_q;
    ob_nx   = ob_q;
    wr_en   = 1'b0;
    if (!cs_act) begin
      cnt_nx = '0;
      oe_nx  = 1'b0;
      ob_nx  = 1'b0;
    end else if (sclk_rise && cnt_q != C_END) begin
      sh_nx  = {sh_q[SH_W-2:0], sdi};
      cnt_nx = cnt_q + 1'b1;
      if (cnt_q == C_ADDR_LAST) begin
        rw_nx   = sh_q[ADDR_W-1];
        addr_nx = {sh_q[ADDR_W-2:0], sdi};
      end
      if (cnt_q == C_LAST && !rw_q) wr_en = 1'b1;
    end else if (sclk_fall) begin
      if (cnt_q == C_DATA_FST && rw_q) begin
        oe_nx = 1'b1;
        ob_nx = rd_data[DATA_W-1];
        tx_nx = {rd_data[DATA_W-2:0], 1'b0};
      end else if (cnt_q == C_END) begin
        oe_nx = 1'b0;
        ob_nx = 1'b0;
      end else if (oe_q) begin
        ob_nx = tx_q[DATA_W-1];
        tx_nx = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      addr_q <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      ob_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      sh_q   <= sh_nx;
      rw_q   <= rw_nx;
      addr_q <= addr_nx;
      tx_q   <= tx_nx;
      oe_q   <= oe_nx;
      ob_q   <= ob_nx;
    end
  end

  assign addr    = addr_q;
  assign rd_flag = rw_q;
  assign out_en  = oe_q;
  assign out_bit = ob_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int IMG_W = CTRL_W + 3 * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  addr_t            addr,
  input  byte_t            wr_data,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z,
  output byte_t            rd_data,
  output logic             wire3,
  output logic [IMG_W-1:0] state_img
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int PAD    = WORD_W - SMP_W;

  byte_t             trim_q [3];
  byte_t             trim_nx [3];
  logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
  logic [SMP_W-1:0]  smp  [3];
  logic [WORD_W-1:0] word [3];

  assign smp[0] = smp_x;
  assign smp[1] = smp_y;
  assign smp[2] = smp_z;

  for (genvar a = 0; a < 3; a++) begin : g_fmt
    assign word[a] = ctrl_q[CTRL_LJUST] ? {smp[a], {PAD{1'b0}}}
                                        : {{PAD{smp[a][SMP_W-1]}}, smp[a]};
  end

  always_comb begin
    trim_nx = trim_q;
    ctrl_nx = ctrl_q;
    if (wr_en) begin
      case (addr)
        A_TRIM_X: trim_nx[0] = wr_data;
        A_TRIM_Y: trim_nx[1] = wr_data;
        A_TRIM_Z: trim_nx[2] = wr_data;
        A_CTRL:   ctrl_nx    = wr_data[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '{default: '0};
      ctrl_q <= '0;
    end else begin
      trim_q <= trim_nx;
      ctrl_q <= ctrl_nx;
    end
  end

  always_comb begin
    case (addr)
      A_TRIM_X: rd_data = trim_q[0];
      A_TRIM_Y: rd_data = trim_q[1];
      A_TRIM_Z: rd_data = trim_q[2];
      A_CTRL:   rd_data = DATA_W'(ctrl_q);
      A_X_LO:   rd_data = word[0][DATA_W-1:0];
      A_X_HI:   rd_data = word[0][WORD_W-1:DATA_W];
      A_Y_LO:   rd_data = word[1][DATA_W-1:0];
      A_Y_HI:   rd_data = word[1][WORD_W-1:DATA_W];
      A_Z_LO:   rd_data = word[2][DATA_W-1:0];
      A_Z_HI:   rd_data = word[2][WORD_W-1:DATA_W];
      default:  rd_data = '0;
    endcase
  end

  assign wire3     = ctrl_q[CTRL_WIRE3];
  assign state_img = {ctrl_q, trim_q[2], trim_q[1], trim_q[0]};
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SMP_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             miso_o,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z
);
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int IMG_W = CTRL_W + 3 * DATA_W;

  logic             rst_sn, cs_act, sclk_rise, sclk_fall, sdi_s;
  logic             wr_en, rd_flag, out_en, out_bit, wire3;
  addr_t            addr;
  byte_t            wr_data, rd_data;
  logic [CNT_W-1:0] bit_cnt;
  logic [IMG_W-1:0] state_img;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .sdi(sdio_i),
    .rst_sn(rst_sn), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s)
  );

  spi_frame_engine #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_sn), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi(sdi_s), .rd_data(rd_data), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_flag(rd_flag), .out_en(out_en),
    .out_bit(out_bit), .bit_cnt(bit_cnt)
  );

  spi_reg_bank #(.SMP_W(SMP_W), .IMG_W(IMG_W)) u_bank (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .rd_data(rd_data),
    .wire3(wire3), .state_img(state_img)
  );

  assign sdio_o  = out_bit;
  assign sdio_oe = out_en & wire3;
  assign miso_o  = out_en & ~wire3 & out_bit;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int CNT_W = 5,
  parameter int IMG_W = 26,
  parameter int FRAME = 16,
  parameter int DFST  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rd_flag,
  input logic             out_en,
  input logic             sdio_oe,
  input logic             miso_o,
  input logic [IMG_W-1:0] state_img
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!sdio_oe && !miso_o));

  // R5
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> (rd_flag && bit_cnt == CNT_W'(DFST)));

  // R2
  write_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_img != $past(state_img)) |->
      ($past(bit_cnt) == CNT_W'(FRAME - 1) && $past(sclk_rise) && !$past(rd_flag)));

  // R3
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (bit_cnt >= CNT_W'(DFST)));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .CNT_W(CNT_W), .IMG_W(IMG_W), .FRAME(spi_reg_pkg::FRAME), .DFST(spi_reg_pkg::ADDR_W + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .bit_cnt(bit_cnt), .rd_flag(rd_flag), .out_en(out_en), .sdio_oe(sdio_oe),
  .miso_o(miso_o), .state_img(state_img)
);

// File: tb/tb_spi_reg_slave.sv
`timescale 1ns/1ps
module tb_spi_reg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdio_o, sdio_oe, miso_o;
  logic [11:0] sx = '0, sy = '0, sz = '0;

  int errors = 0, checks = 0, idle_cnt = 0;
  bit done = 0;

  // behavioural model of the register state
  logic [7:0] m_trim [3];
  logic [1:0] m_ctrl;

  always #10ns clk = ~clk;

  spi_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .miso_o(miso_o),
    .smp_x(sx), .smp_y(sy), .smp_z(sz)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    logic [11:0] s;
    logic [15:0] w;
    case (a)
      7'h16, 7'h17, 7'h18: return m_trim[a - 7'h16];
      7'h20: return {6'b0, m_ctrl};
      7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D: begin
        s = (a < 7'h2A) ? sx : (a < 7'h2C) ? sy : sz;
        w = m_ctrl[1] ? {s, 4'b0000} : {{4{s[11]}}, s};
        return a[0] ? w[15:8] : w[7:0];
      end
      default: return 8'h00;
    endcase
  endfunction

  // R10: every clock with chip select settled high, outputs are quiet
  always @(negedge clk) begin
    if (!rst_n || !cs_n) idle_cnt = 0;
    else begin
      idle_cnt++;
      if (idle_cnt >= 6) chk("R10 idle outputs", {sdio_oe, miso_o}, 2'b00);
    end
  end

  task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rd);
    logic [15:0] fr;
    logic [7:0]  exp;
    fr  = {rw, a, wd};
    exp = exp_rd(a);
    rd  = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = (rw && i >= 8) ? 1'b1 : fr[15 - i];
      repeat (HALF) @(negedge clk);
      if (rw && i >= 8) begin
        if (m_ctrl[0]) begin
          rd[15 - i] = sdio_o;
          chk("R5 oe high in data phase", sdio_oe, 1'b1);
          chk("R5 miso quiet in 3-wire", miso_o, 1'b0);
        end else begin
          rd[15 - i] = miso_o;
          chk("R4 oe low in 4-wire", sdio_oe, 1'b0);
        end
      end else if (i < 8) begin
        chk("R5 no drive in command phase", {sdio_oe, miso_o}, 2'b00);
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    if (rw && nbits == 16) chk("R3 read byte", rd, exp);
    if (!rw && nbits == 16) begin
      if (a >= 7'h16 && a <= 7'h18) m_trim[a - 7'h16] = wd;
      else if (a == 7'h20) m_ctrl = wd[1:0];
    end
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [7:0] exp);
    logic [7:0] r;
    xfer(1'b1, a, 8'h00, 16, r);
    chk(tag, r, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b0, a, d, 16, r);
  endtask

  initial begin
    logic [7:0] r;
    m_trim = '{default: 8'h00};
    m_ctrl = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1
    chk("R1 outputs after reset", {sdio_oe, miso_o}, 2'b00);
    rd_chk("R1 trim x reset", 7'h16, 8'h00);
    rd_chk("R1 ctrl reset", 7'h20, 8'h00);
    // R2 R4
    wr(7'h16, 8'hA5); wr(7'h17, 8'h3C); wr(7'h18, 8'h81);
    rd_chk("R2 trim x", 7'h16, 8'hA5);
    rd_chk("R2 trim y", 7'h17, 8'h3C);
    rd_chk("R4 trim z 4-wire", 7'h18, 8'h81);
    wr(7'h20, 8'hFC);
    rd_chk("R2 ctrl upper bits dropped", 7'h20, 8'h00);
    // R6
    sx = 12'h9A5; sy = 12'h3C1; sz = 12'h800;
    rd_chk("R6 x lo", 7'h28, 8'hA5);
    rd_chk("R6 x hi sign", 7'h29, 8'hF9);
    rd_chk("R6 y lo", 7'h2A, 8'hC1);
    rd_chk("R6 y hi", 7'h2B, 8'h03);
    rd_chk("R6 z hi", 7'h2D, 8'hF8);
    // R7
    wr(7'h20, 8'h02);
    rd_chk("R7 x hi", 7'h29, 8'h9A);
    rd_chk("R7 x lo", 7'h28, 8'h50);
    rd_chk("R7 y lo", 7'h2A, 8'h10);
    // R5: 3-wire with left justify, then right justify
    wr(7'h20, 8'h03);
    rd_chk("R5 ctrl 3-wire", 7'h20, 8'h03);
    rd_chk("R5 trim y 3-wire", 7'h17, 8'h3C);
    rd_chk("R5 z lo", 7'h2C, 8'h00);
    wr(7'h20, 8'h01);
    rd_chk("R5 y hi right", 7'h2B, 8'h03);
    // R8: aborted frames
    xfer(1'b0, 7'h16, 8'h11, 10, r);
    xfer(1'b0, 7'h16, 8'h22, 15, r);
    rd_chk("R8 abort keeps trim", 7'h16, 8'hA5);
    // R9
    wr(7'h2A, 8'h55);
    wr(7'h05, 8'hEE);
    rd_chk("R9 data byte unchanged", 7'h2A, 8'hC1);
    rd_chk("R9 reserved reads zero", 7'h05, 8'h00);
    rd_chk("R9 reserved reads zero high", 7'h7F, 8'h00);
    rd_chk("R9 trims intact", 7'h18, 8'h81);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule